// File: doc/BRIEF.md
# Receiver Recovered-Clock Phase Aligner

This block gives a serial receiver a fixed, known latency by steering the phase of its recovered clock. Two receivers are compared. Lane 0 is the untouched time reference. Lane 1 is the lane being aligned. Each time lane 1's receiver is reset, its clock-and-data-recovery circuit may settle on any of the ten bit positions of a 10-bit code word. The aligner therefore keeps resetting lane 1 until the wanted position comes up. It does not move any delay element, and it does not judge word boundaries, because those are found later in logic.

Both lanes present a one-cycle marker pulse in one common sample clock domain. The phase of lane 1 is the number of sample cycles from a lane 0 marker to the next lane 1 marker. A run has two stages. In the first, lane 1 is reset again and again, and the largest offset seen is recorded, until the largest possible offset (nine) appears. In the second, resets continue until the configured target phase, normally the earliest one, is measured.

A single start pulse runs the whole sequence, and it is accepted only once the transmit side reports that it is synchronized. The block ends with either done or error.

Top module: `rx_phase_aligner`

## Requirements
- R1: After reset, tgtRxReset, done and error are low, and measPhase and maxPhase are 0.
- R2: start is taken only when the block is idle and txSynced is high. A start while a run is in progress, or while txSynced is low, has no effect.
- R3: Each reset pulse holds tgtRxReset high for exactly PULSE_LEN cycles (8). The first pulse begins in the cycle after start is sampled. Each pulse is followed by SETTLE_LEN cycles (256) with tgtRxReset low before the lock flags are sampled.
- R4: If refLocked and tgtLocked are not both high at the end of the settle window, a new pulse starts at once. That attempt does not count toward the attempt limit.
- R5: The measured phase is the number of cycles from a refMarker to the next tgtMarker. It is 0 when both markers arrive in the same cycle, and it saturates at SAT_LIMIT (15). measPhase takes each measured value. If nothing is measured within MEAS_TIMEOUT cycles (64), a new pulse starts and the attempt is not counted.
- R6: In stage one, maxPhase holds the largest phase measured in the current run. Stage one ends when phase PHASES-1 (9) is measured.
- R7: Stage two pulses until the measured phase equals targetPhase (4 bits). Then done goes high and tgtRxReset stays low.
- R8: done and error hold until the next accepted start, which clears done, error and maxPhase.
- R9: error goes high, and the run ends, when a stage has counted MAX_ATTEMPTS measurements (64) without reaching its goal. In stage one a target match does not end the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sample clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an alignment run |
| txSynced | input | 1 | Transmit side synchronized; gates start |
| targetPhase | input | 4 | Phase to reach in stage two |
| refMarker | input | 1 | Marker pulse of reference lane 0 |
| tgtMarker | input | 1 | Marker pulse of target lane 1 |
| refLocked | input | 1 | Lane 0 receiver locked |
| tgtLocked | input | 1 | Lane 1 receiver locked |
| tgtRxReset | output | 1 | Reset to the lane 1 receiver |
| measPhase | output | 4 | Last measured phase |
| maxPhase | output | 4 | Largest phase measured in stage one |
| done | output | 1 | Alignment reached |
| error | output | 1 | Attempt limit exhausted |

## Verification
The main run is driven with scripted sequences of lane 1 phases after each reset. These scripts separate several cases: a stage-one hit on the largest offset followed by a stage-two hit on the target, a target of zero where the markers coincide, a stage two that never sees the target, and a stage one that never sees offset nine even though the target phase appears. Other attempts in the scripts withhold lock, withhold all markers, or withhold only the lane 1 marker. These tell apart the uncounted retries, the measurement timeout and the saturating count. Extra start pulses, given while a run is active and while txSynced is low, show whether the gating holds.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  typedef struct packed {
    logic loadPulse;
    logic loadSettle;
    logic loadMeas;
    logic meterArm;
    logic meterEn;
    logic attemptClr;
    logic attemptInc;
    logic maxClr;
    logic maxEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/rpa_datapath.sv
module rpa_datapath
  import rpa_pkg::*;
#(
  parameter int PHASE_W      = 4,
  parameter int PULSE_LEN    = 8,
  parameter int SETTLE_LEN   = 256,
  parameter int MEAS_TIMEOUT = 64,
  parameter int SAT_LIMIT    = 15,
  parameter int MAX_ATTEMPTS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobe,
  input  logic               refMarker,
  input  logic               tgtMarker,
  output logic               timerZero,
  output logic               capValid,
  output logic [PHASE_W-1:0] capPhase,
  output logic               attemptsLast,
  output logic [PHASE_W-1:0] measPhase,
  output logic [PHASE_W-1:0] maxPhase
);
  localparam int TIMER_MAX = (SETTLE_LEN > PULSE_LEN) ?
                             ((SETTLE_LEN > MEAS_TIMEOUT) ? SETTLE_LEN : MEAS_TIMEOUT) :
                             ((PULSE_LEN > MEAS_TIMEOUT) ? PULSE_LEN : MEAS_TIMEOUT);
  localparam int TIMER_W = $clog2(TIMER_MAX + 1);
  localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [TIMER_W-1:0] PULSE_LOAD  = TIMER_W'(PULSE_LEN - 1);
  localparam logic [TIMER_W-1:0] SETTLE_LOAD = TIMER_W'(SETTLE_LEN - 1);
  localparam logic [TIMER_W-1:0] MEAS_LOAD   = TIMER_W'(MEAS_TIMEOUT - 1);
  localparam logic [PHASE_W-1:0] SAT_VAL     = PHASE_W'(SAT_LIMIT);
  localparam logic [ATT_W-1:0]   ATT_LAST    = ATT_W'(MAX_ATTEMPTS - 1);

  logic [TIMER_W-1:0] timer;
  logic [ATT_W-1:0]   attempts;
  logic               armed;
  logic [PHASE_W-1:0] cnt;

  // shared down-counter for pulse, settle and measurement windows
  always_ff @(posedge clk) begin
    if (rst)                    timer <= '0;
    else if (strobe.loadPulse)  timer <= PULSE_LOAD;
    else if (strobe.loadSettle) timer <= SETTLE_LOAD;
    else if (strobe.loadMeas)   timer <= MEAS_LOAD;
    else if (timer != '0)       timer <= timer - 1'b1;
  end
  assign timerZero = (timer == '0);

  // phase meter: reference marker arms, target marker captures
  always_comb begin
    capValid = 1'b0;
    capPhase = '0;
    if (strobe.meterEn) begin
      if (armed) begin
        capValid = tgtMarker || (cnt == SAT_VAL);
        capPhase = cnt;
      end else begin
        capValid = refMarker && tgtMarker;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.meterArm) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (strobe.meterEn && !capValid) begin
      if (!armed && refMarker) begin
        armed <= 1'b1;
        cnt   <= PHASE_W'(1);
      end else if (armed) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // counted measurements within the current stage
  always_ff @(posedge clk) begin
    if (rst || strobe.attemptClr) attempts <= '0;
    else if (strobe.attemptInc)   attempts <= attempts + 1'b1;
  end
  assign attemptsLast = (attempts == ATT_LAST);

  always_ff @(posedge clk) begin
    if (rst)           measPhase <= '0;
    else if (capValid) measPhase <= capPhase;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.maxClr) maxPhase <= '0;
    else if (capValid && strobe.maxEn && (capPhase > maxPhase)) maxPhase <= capPhase;
  end

  assert_meas_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !capValid |=> $stable(measPhase));
  assert_max_mono_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe.maxClr |=> (maxPhase >= $past(maxPhase)));
  assert_attempt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    attempts <= ATT_W'(MAX_ATTEMPTS));
endmodule

// File: rtl/rpa_ctrl.sv
module rpa_ctrl
  import rpa_pkg::*;
#(
  parameter int PHASE_W = 4,
  parameter int PHASES  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               txSynced,
  input  logic [PHASE_W-1:0] targetPhase,
  input  logic               refLocked,
  input  logic               tgtLocked,
  input  logic               timerZero,
  input  logic               capValid,
  input  logic [PHASE_W-1:0] capPhase,
  input  logic               attemptsLast,
  output ctrlStrobe_t        strobe,
  output logic               tgtRxReset,
  output logic               done,
  output logic               error
);
  localparam logic [PHASE_W-1:0] TOP_PHASE = PHASE_W'(PHASES - 1);

  typedef enum logic [1:0] {sIdle, sPulse, sSettle, sMeasure} state_t;
  state_t state, stateNext;
  logic stageTwo, stageTwoNext;
  logic setDone, setErr, clrFlags;

  always_comb begin
    strobe       = '0;
    stateNext    = state;
    stageTwoNext = stageTwo;
    setDone      = 1'b0;
    setErr       = 1'b0;
    clrFlags     = 1'b0;
    strobe.meterEn = (state == sMeasure);
    strobe.maxEn   = !stageTwo;
    case (state)
      sIdle: if (start && txSynced) begin
        stateNext         = sPulse;
        stageTwoNext      = 1'b0;
        clrFlags          = 1'b1;
        strobe.loadPulse  = 1'b1;
        strobe.attemptClr = 1'b1;
        strobe.maxClr     = 1'b1;
      end
      sPulse: if (timerZero) begin
        stateNext         = sSettle;
        strobe.loadSettle = 1'b1;
      end
      sSettle: if (timerZero) begin
        if (refLocked && tgtLocked) begin
          stateNext       = sMeasure;
          strobe.loadMeas = 1'b1;
          strobe.meterArm = 1'b1;
        end else begin
          stateNext        = sPulse;
          strobe.loadPulse = 1'b1;
        end
      end
      sMeasure: begin
        if (capValid) begin
          strobe.attemptInc = 1'b1;
          if (!stageTwo && capPhase == TOP_PHASE) begin
            stageTwoNext      = 1'b1;
            strobe.attemptClr = 1'b1;
            stateNext         = sPulse;
            strobe.loadPulse  = 1'b1;
          end else if (stageTwo && capPhase == targetPhase) begin
            stateNext = sIdle;
            setDone   = 1'b1;
          end else if (attemptsLast) begin
            stateNext = sIdle;
            setErr    = 1'b1;
          end else begin
            stateNext        = sPulse;
            strobe.loadPulse = 1'b1;
          end
        end else if (timerZero) begin
          stateNext        = sPulse;
          strobe.loadPulse = 1'b1;
        end
      end
      default: stateNext = sIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= sIdle;
      stageTwo <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      state    <= stateNext;
      stageTwo <= stageTwoNext;
      if (clrFlags) begin
        done  <= 1'b0;
        error <= 1'b0;
      end else begin
        if (setDone) done  <= 1'b1;
        if (setErr)  error <= 1'b1;
      end
    end
  end

  assign tgtRxReset = (state == sPulse);

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (state == sIdle && start && txSynced) |=> (!done && !error && tgtRxReset));
  assert_quiet_after_end_R7: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> !tgtRxReset);
  assert_pulse_min_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tgtRxReset) |=> tgtRxReset);
endmodule

// File: rtl/rx_phase_aligner.sv
module rx_phase_aligner
  import rpa_pkg::*;
#(
  parameter int PHASE_W      = 4,
  parameter int PHASES       = 10,
  parameter int PULSE_LEN    = 8,
  parameter int SETTLE_LEN   = 256,
  parameter int MEAS_TIMEOUT = 64,
  parameter int SAT_LIMIT    = 15,
  parameter int MAX_ATTEMPTS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               txSynced,
  input  logic [PHASE_W-1:0] targetPhase,
  input  logic               refMarker,
  input  logic               tgtMarker,
  input  logic               refLocked,
  input  logic               tgtLocked,
  output logic               tgtRxReset,
  output logic [PHASE_W-1:0] measPhase,
  output logic [PHASE_W-1:0] maxPhase,
  output logic               done,
  output logic               error
);
  ctrlStrobe_t        strobe;
  logic               timerZero, capValid, attemptsLast;
  logic [PHASE_W-1:0] capPhase;

  rpa_datapath #(
    .PHASE_W(PHASE_W), .PULSE_LEN(PULSE_LEN), .SETTLE_LEN(SETTLE_LEN),
    .MEAS_TIMEOUT(MEAS_TIMEOUT), .SAT_LIMIT(SAT_LIMIT), .MAX_ATTEMPTS(MAX_ATTEMPTS)
  ) uDatapath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .refMarker(refMarker), .tgtMarker(tgtMarker),
    .timerZero(timerZero), .capValid(capValid), .capPhase(capPhase),
    .attemptsLast(attemptsLast), .measPhase(measPhase), .maxPhase(maxPhase)
  );

  rpa_ctrl #(.PHASE_W(PHASE_W), .PHASES(PHASES)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .txSynced(txSynced),
    .targetPhase(targetPhase), .refLocked(refLocked), .tgtLocked(tgtLocked),
    .timerZero(timerZero), .capValid(capValid), .capPhase(capPhase),
    .attemptsLast(attemptsLast), .strobe(strobe),
    .tgtRxReset(tgtRxReset), .done(done), .error(error)
  );
endmodule

// File: tb/rx_phase_aligner_test.sv
module rx_phase_aligner_test;
  localparam int PHASES = 10, PULSE_LEN = 8, SETTLE_LEN = 256;
  localparam int MEAS_TIMEOUT = 64, SAT_LIMIT = 15, MAX_ATTEMPTS = 64;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, txSynced = 1'b0;
  logic [3:0] targetPhase = 4'd0;
  logic refMarker = 1'b0, tgtMarker = 1'b0, refLocked = 1'b1, tgtLocked = 1'b0;
  logic tgtRxReset, done, error;
  logic [3:0] measPhase, maxPhase;

  rx_phase_aligner uut (
    .clk(clk), .rst(rst), .start(start), .txSynced(txSynced),
    .targetPhase(targetPhase), .refMarker(refMarker), .tgtMarker(tgtMarker),
    .refLocked(refLocked), .tgtLocked(tgtLocked), .tgtRxReset(tgtRxReset),
    .measPhase(measPhase), .maxPhase(maxPhase), .done(done), .error(error)
  );

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // lane emulation: phase script; -1 no lock, -2 no markers at all, -3 no lane 1 marker
  int phaseQ[$];
  int defaultPhase = 0;
  int curPhase = 0;
  bit noLock = 1'b0, noMarks = 1'b0, noTgt = 1'b0;
  int tick = 0;
  logic prevRst = 1'b0;

  always @(negedge clk) begin
    int code;
    tick++;
    if (tgtRxReset && !prevRst) begin
      code = (phaseQ.size() != 0) ? phaseQ.pop_front() : defaultPhase;
      noLock = (code == -1); noMarks = (code == -2); noTgt = (code == -3);
      curPhase = (code >= 0) ? code : 0;
    end
    prevRst   = tgtRxReset;
    refMarker <= !noMarks && (tick % PHASES == 0);
    tgtMarker <= !noMarks && !noTgt && ((tick + PHASES - curPhase) % PHASES == 0);
    tgtLocked <= !tgtRxReset && !noLock;
  end

  // behavioural reference model, stepping on the clock
  logic expReset = 1'b0, expDone = 1'b0, expErr = 1'b0;
  int expMeas = 0, expMax = 0;

  task automatic runModel();
    bit stage2 = 1'b0, got, armed;
    int attempts = 0, cnt, p;
    expDone = 1'b0; expErr = 1'b0; expMax = 0;
    forever begin
      expReset = 1'b1;
      repeat (PULSE_LEN) @(posedge clk);
      expReset = 1'b0;
      repeat (SETTLE_LEN) @(posedge clk);
      if (!(refLocked && tgtLocked)) continue;
      got = 1'b0; armed = 1'b0; cnt = 0; p = 0;
      for (int t = 0; t < MEAS_TIMEOUT && !got; t++) begin
        @(posedge clk);
        if (!armed) begin
          if (refMarker && tgtMarker) begin got = 1'b1; p = 0; end
          else if (refMarker) begin armed = 1'b1; cnt = 1; end
        end else if (tgtMarker || cnt == SAT_LIMIT) begin
          got = 1'b1; p = cnt;
        end else cnt++;
      end
      if (!got) continue;
      expMeas = p;
      attempts++;
      if (!stage2) begin
        if (p > expMax) expMax = p;
        if (p == PHASES - 1) begin stage2 = 1'b1; attempts = 0; continue; end
      end else if (p == int'(targetPhase)) begin
        expDone = 1'b1; return;
      end
      if (attempts == MAX_ATTEMPTS) begin expErr = 1'b1; return; end
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (!rst && start && txSynced) runModel();
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!rst && !finished) begin
    check("R3 tgtRxReset", tgtRxReset, expReset);
    check("R5 measPhase", measPhase, expMeas);
    check("R6 maxPhase", maxPhase, expMax);
    check("R7 done", done, expDone);
    check("R9 error", error, expErr);
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitEnd();
    do @(negedge clk); while (!(done || error));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog expired before the run finished");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 tgtRxReset", tgtRxReset, 0);
    check("R1 done", done, 0);
    check("R1 error", error, 0);
    check("R1 measPhase", measPhase, 0);
    check("R1 maxPhase", maxPhase, 0);
    rst = 1'b0;

    // R2: start without txSynced is ignored
    pulseStart();
    repeat (20) @(negedge clk);
    check("R2 no pulse while txSynced low", tgtRxReset, 0);
    txSynced = 1'b1;

    // main run: lock loss (R4), marker timeout (R5), stage change (R6), target hit (R7)
    targetPhase = 4'd2; defaultPhase = 5;
    phaseQ = '{3, -1, 7, -2, 9, 4, 2};
    pulseStart();
    repeat (100) @(negedge clk);
    pulseStart();                          // R2: ignored while busy
    waitEnd();
    check("R7 done after target", done, 1);
    check("R5 measPhase is target", measPhase, 2);
    check("R6 maxPhase reached 9", maxPhase, 9);

    // R9: stage two never sees the target; R8: start clears done
    targetPhase = 4'd6; defaultPhase = 4;
    phaseQ = '{9};
    pulseStart();
    check("R8 done cleared by start", done, 0);
    waitEnd();
    check("R9 error in stage two", error, 1);
    check("R9 done stays low", done, 0);

    // earliest target phase with coincident markers (R7), R8 clears error and maxPhase
    targetPhase = 4'd0; defaultPhase = 3;
    phaseQ = '{5, 9, 0};
    pulseStart();
    check("R8 error cleared by start", error, 0);
    check("R8 maxPhase cleared by start", maxPhase, 0);
    waitEnd();
    check("R7 done at phase 0", done, 1);
    check("R5 coincident markers give 0", measPhase, 0);

    // stage one never sees 9; saturated count (R5); target match ignored in stage one (R9)
    targetPhase = 4'd2; defaultPhase = 2;
    phaseQ = '{1, -3, 3};
    pulseStart();
    waitEnd();
    check("R9 error in stage one", error, 1);
    check("R5 saturated maximum", maxPhase, SAT_LIMIT);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule